// File: doc/BRIEF.md
# Self-Timed Convert Trigger Bus Interface

This block sits between an 8-bit processor bus and a 10-bit successive-approximation converter that is started through a single blank/convert line. Software starts a conversion with one write to the start address. The write sets a flip-flop that drives the blank/convert line high. The converter answers by raising its busy/not-ready line. Once that rise is seen, the flip-flop clears and the line returns low, which begins the conversion. The width of the convert pulse is therefore set by the converter's own response, and no pulse-width timer is needed.

While idle, the blank/convert line stays low and the converter keeps its last result on its outputs. Software polls a status address until the not-ready line is low again. It then reads the result as two bus words. A parameter selects how the 10 result bits are split across the two words. A word is driven onto the read bus only while the chip-select decode and the read strobe are both low. The bus enable drops in the same cycle the read strobe goes inactive.

Top module: `conv_trigger_bus`

## Requirements
- R1: After reset, `blank_conv_o` is 0, `rd_en_o` is 0 and `rd_data_o` is 0.
- R2: A start write raises `blank_conv_o` at the first rising clock edge that samples it. A start write is a 1-to-0 transition of `wr_ni`, sampled while `cs_ni` is 0 and `sel_i` is 3.
- R3: `blank_conv_o` returns to 0 on the (SYNC_STAGES+1)-th rising clock edge after `done_n_i` rises. With the default of 2 stages, this is the 3rd edge.
- R4: With LEFT_JUST=1, word 0 (`sel_i`=0) returns result bits [9:2], and word 1 (`sel_i`=1) returns result bits [1:0] in bus bits [7:6]. With LEFT_JUST=0, word 0 returns result bits [7:0], and word 1 returns result bits [9:8] in bus bits [1:0]. Unused bits of word 1 read as 0.
- R5: `rd_en_o` is 1 only while `cs_ni` is 0, `rd_ni` is 0 and `sel_i` is not 3. Whenever `rd_en_o` is 0, `rd_data_o` is 0.
- R6: `rd_en_o` falls in the same cycle that `rd_ni` goes high, with no register delay.
- R7: A status read (`sel_i`=2) returns the synchronised `done_n_i` in bus bit 0 and 0 in bits [7:1].
- R8: A start write is ignored while `blank_conv_o` is 1 or while the synchronised `done_n_i` is 1. An ignored start does not raise `blank_conv_o` afterwards.
- R9: Only the falling edge of `wr_ni` starts a conversion. Holding `wr_ni` low does not start a second one. Writes with `sel_i` other than 3 have no effect on `blank_conv_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Address decode strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| rd_ni | input | 1 | Read strobe, active low |
| sel_i | input | 2 | Word select: 0 word 0, 1 word 1, 2 status, 3 start |
| done_n_i | input | 1 | Converter not-ready line: high while blanked or converting, low when the result is valid |
| result_i | input | RES_W | Converter result bits |
| rd_data_o | output | BUS_W | Read bus data |
| rd_en_o | output | 1 | Read bus drive enable |
| blank_conv_o | output | 1 | Blank/convert line to the converter |

## Verification
The embedded assertions check on every cycle that:
- the start flop clears one edge after the synchronised not-ready rise;
- the start flop never sets while the converter is busy or already triggered;
- the read enable is low whenever the read strobe is high;
- the read data is zero whenever the enable is low;
- status reads carry only bit 0.

Some behaviours only the bench's scenarios can show. These are the exact edge count from a not-ready rise to the end of the pulse, and the correct bit packing of real results under both justification settings. They also include the rejection of start writes issued during each busy phase, and the rejection of a write strobe that is held low across a completion.

// File: rtl/conv_trigger_bus_pkg.sv
package conv_trigger_bus_pkg;
  typedef enum logic [1:0] {
    SEL_W0    = 2'd0,
    SEL_W1    = 2'd1,
    SEL_STAT  = 2'd2,
    SEL_START = 2'd3
  } word_sel_e;
endpackage

// File: rtl/ctb_sync.sv
module ctb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] st_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= {st_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/ctb_start_ctl.sv
module ctb_start_ctl
  import conv_trigger_bus_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       wr_ni,
  input  logic [1:0] sel_i,
  input  logic       busy_i,
  output logic       start_o
);
  logic wr_q;
  logic busy_d;
  logic start_q;
  logic wr_evt;
  logic busy_rise;

  assign wr_evt    = wr_q & ~wr_ni & ~cs_ni & (word_sel_e'(sel_i) == SEL_START);
  assign busy_rise = busy_i & ~busy_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= 1'b1;
      busy_d <= 1'b0;
    end else begin
      wr_q   <= wr_ni;
      busy_d <= busy_i;
    end
  end

  // clear wins: the converter's answer ends the pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             start_q <= 1'b0;
    else if (busy_rise)                      start_q <= 1'b0;
    else if (wr_evt && !busy_i && !start_q)  start_q <= 1'b1;
  end

  assign start_o = start_q;

  AST_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !busy_d) |=> !start_q); // R3
  AST_NO_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !start_q) |=> !start_q); // R8
  AST_START_NEEDS_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(start_q) |-> $past(!wr_ni && !cs_ni)); // R2
endmodule

// File: rtl/ctb_rd_mux.sv
module ctb_rd_mux
  import conv_trigger_bus_pkg::*;
#(
  parameter int RES_W      = 10,
  parameter int BUS_W      = 8,
  parameter bit LEFT_JUST  = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             rd_ni,
  input  logic [1:0]       sel_i,
  input  logic             busy_i,
  input  logic [RES_W-1:0] result_i,
  output logic [BUS_W-1:0] rd_data_o,
  output logic             rd_en_o
);
  localparam int LO_W  = RES_W - BUS_W;
  localparam int PAD_W = BUS_W - LO_W;

  logic [BUS_W-1:0] w0;
  logic [BUS_W-1:0] w1;
  logic [BUS_W-1:0] stat_w;

  generate
    if (LEFT_JUST) begin : g_left
      assign w0 = result_i[RES_W-1 -: BUS_W];
      assign w1 = {result_i[LO_W-1:0], {PAD_W{1'b0}}};
    end else begin : g_right
      assign w0 = result_i[BUS_W-1:0];
      assign w1 = {{PAD_W{1'b0}}, result_i[RES_W-1 -: LO_W]};
    end
  endgenerate

  assign stat_w = {{(BUS_W-1){1'b0}}, busy_i};

  // purely combinational so the enable follows the strobe without delay
  always_comb begin
    rd_en_o   = ~cs_ni & ~rd_ni & (word_sel_e'(sel_i) != SEL_START);
    rd_data_o = '0;
    if (rd_en_o) begin
      unique case (word_sel_e'(sel_i))
        SEL_W0:   rd_data_o = w0;
        SEL_W1:   rd_data_o = w1;
        SEL_STAT: rd_data_o = stat_w;
        default:  rd_data_o = '0;
      endcase
    end
  end

  AST_EN_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ni |-> !rd_en_o); // R6
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_o |-> (rd_data_o == '0)); // R5
  AST_STAT_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_o && sel_i == 2'd2) |-> (rd_data_o[BUS_W-1:1] == '0)); // R7
endmodule

// File: rtl/conv_trigger_bus.sv
module conv_trigger_bus #(
  parameter int RES_W       = 10,
  parameter int BUS_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit LEFT_JUST   = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             wr_ni,
  input  logic             rd_ni,
  input  logic [1:0]       sel_i,
  input  logic             done_n_i,
  input  logic [RES_W-1:0] result_i,
  output logic [BUS_W-1:0] rd_data_o,
  output logic             rd_en_o,
  output logic             blank_conv_o
);
  logic busy_s;

  ctb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (done_n_i),
    .q_o    (busy_s)
  );

  ctb_start_ctl u_start (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_ni   (cs_ni),
    .wr_ni   (wr_ni),
    .sel_i   (sel_i),
    .busy_i  (busy_s),
    .start_o (blank_conv_o)
  );

  ctb_rd_mux #(.RES_W(RES_W), .BUS_W(BUS_W), .LEFT_JUST(LEFT_JUST)) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_ni     (cs_ni),
    .rd_ni     (rd_ni),
    .sel_i     (sel_i),
    .busy_i    (busy_s),
    .result_i  (result_i),
    .rd_data_o (rd_data_o),
    .rd_en_o   (rd_en_o)
  );

  AST_PULSE_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_conv_o && busy_s && $past(busy_s)) |-> 1'b0); // R3
endmodule

// File: tb/sim_conv_trigger_bus.sv
module sim_conv_trigger_bus;
  localparam int CLK_P    = 10;
  localparam int SYNC     = 2;
  localparam int CONV_CYC = 12;
  localparam int LIMIT    = 20000;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_ni = 1'b1, wr_ni = 1'b1, rd_ni = 1'b1;
  logic [1:0] sel = 2'd0;
  logic       done_n = 1'b0;
  logic [9:0] res = 10'h000;
  logic [7:0] d0, d1;
  logic       en0, en1, bc, bc1;

  int checks = 0, errors = 0;
  int cyc = 0;
  bit done_flag = 0;

  always #(CLK_P/2) clk = ~clk;

  conv_trigger_bus #(.SYNC_STAGES(SYNC), .LEFT_JUST(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .wr_ni(wr_ni), .rd_ni(rd_ni),
    .sel_i(sel), .done_n_i(done_n), .result_i(res),
    .rd_data_o(d0), .rd_en_o(en0), .blank_conv_o(bc));

  conv_trigger_bus #(.SYNC_STAGES(SYNC), .LEFT_JUST(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .wr_ni(wr_ni), .rd_ni(rd_ni),
    .sel_i(sel), .done_n_i(done_n), .result_i(res),
    .rd_data_o(d1), .rd_en_o(en1), .blank_conv_o(bc1));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // behavioural reference model
  bit hist[$];
  bit m_bc;
  bit m_wr_prev;
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      hist = {};
      for (int i = 0; i <= SYNC; i++) hist.push_back(1'b0);
      m_bc = 0;
      m_wr_prev = 1;
    end else begin
      bit busy, rise, evt;
      cyc++;
      busy = hist[SYNC-1];
      rise = hist[SYNC-1] && !hist[SYNC];
      evt  = m_wr_prev && !wr_ni && !cs_ni && sel == 2'd3;
      if (rise) m_bc = 0;
      else if (evt && !busy && !m_bc) m_bc = 1;
      m_wr_prev = wr_ni;
      hist.push_front(done_n);
      void'(hist.pop_back());
    end
  end

  function automatic int exp_word(bit left, bit [1:0] s, bit [9:0] r, bit st);
    if (s == 2'd0) return left ? int'(r >> 2) : int'(r & 10'hFF);
    if (s == 2'd1) return left ? int'((r & 10'h3) << 6) : int'(r >> 8);
    if (s == 2'd2) return int'(st);
    return 0;
  endfunction

  // per-cycle comparison away from the edge
  int rise_cnt = 0;
  int fall_cyc = -1;
  bit bc_prev = 0;
  always @(negedge clk) begin
    #(CLK_P/4);
    if (rst_ni && !done_flag) begin
      bit en_e;
      en_e = !cs_ni && !rd_ni && sel != 2'd3;
      chk("R2/R3 blank_conv", bc, m_bc);
      chk("R2/R3 blank_conv u1", bc1, m_bc);
      chk("R5 enable", en0, en_e);
      chk("R5 enable u1", en1, en_e);
      chk("R4 data left", d0, en_e ? exp_word(1, sel, res, hist[SYNC-1]) : 0);
      chk("R4 data right", d1, en_e ? exp_word(0, sel, res, hist[SYNC-1]) : 0);
      if (bc && !bc_prev) rise_cnt++;
      if (!bc && bc_prev) fall_cyc = cyc;
      bc_prev = bc;
    end
  end

  // converter model
  int cv_st = 0, cv_cnt = 0, rdy_rise_cyc = -1;
  logic [9:0] next_res = 10'h2A5;
  always @(negedge clk) begin
    case (cv_st)
      0: if (bc) begin cv_cnt = 0; cv_st = 1; end
      1: begin cv_cnt++; if (cv_cnt == 3) begin done_n = 1; rdy_rise_cyc = cyc; cv_st = 2; end end
      2: if (!bc) begin cv_cnt = 0; cv_st = 3; end
      default: begin
        cv_cnt++;
        if (cv_cnt == CONV_CYC) begin res = next_res; done_n = 0; cv_st = 0; end
      end
    endcase
  end

  task automatic start_wr(input bit hold_low = 0);
    @(negedge clk); cs_ni = 0; sel = 2'd3;
    @(negedge clk); wr_ni = 0;
    @(negedge clk);
    if (!hold_low) wr_ni = 1;
    cs_ni = 1; sel = 2'd0;
  endtask

  task automatic plain_wr(input bit [1:0] s);
    @(negedge clk); cs_ni = 0; sel = s;
    @(negedge clk); wr_ni = 0;
    @(negedge clk); wr_ni = 1; cs_ni = 1; sel = 2'd0;
  endtask

  task automatic rd_word(input bit [1:0] s, output logic [7:0] v0, output logic [7:0] v1);
    @(negedge clk); cs_ni = 0; sel = s; rd_ni = 0;
    #(CLK_P/4 + 1); v0 = d0; v1 = d1;
    @(negedge clk); rd_ni = 1;
    #1;
    chk("R6 enable drop", en0, 0);
    chk("R6 enable drop u1", en1, 0);
    @(negedge clk); cs_ni = 1;
  endtask

  task automatic wait_done();
    logic [7:0] a, b;
    int n = 0;
    do begin
      rd_word(2'd2, a, b);
      n++;
    end while (a[0] == 1'b1 && n < 200);
    chk("R7 status low at completion", a, 0);
  endtask

  task automatic conv_and_read(input logic [9:0] v);
    logic [7:0] a, b;
    int r0;
    next_res = v;
    r0 = rise_cnt;
    start_wr();
    @(negedge clk); #1;
    chk("R2 convert high", bc, 1);
    wait (cv_st == 3);
    @(negedge clk); #(CLK_P/4 + 1);
    chk("R3 pulse end edge count", fall_cyc - rdy_rise_cyc, SYNC + 1);
    repeat (2) @(negedge clk);
    rd_word(2'd2, a, b);
    chk("R7 status busy", a, 1);
    wait (cv_st == 0);
    repeat (SYNC + 1) @(negedge clk);
    wait_done();
    rd_word(2'd0, a, b);
    chk("R4 word0 left", a, v[9:2]);
    chk("R4 word0 right", b, v[7:0]);
    rd_word(2'd1, a, b);
    chk("R4 word1 left", a, {v[1:0], 6'b0});
    chk("R4 word1 right", b, {6'b0, v[9:8]});
    chk("R2 one pulse per start", rise_cnt - r0, 1);
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] a, b;
    int r0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset convert", bc, 0);
    chk("R1 reset enable", en0, 0);
    chk("R1 reset data", d0, 0);
    rst_ni = 1;
    repeat (2) @(negedge clk);
    rd_word(2'd2, a, b);
    chk("R7 status idle", a, 0);

    conv_and_read(10'h2A5);
    conv_and_read(10'h3FF);
    conv_and_read(10'h000);

    // R8: second start while pulse high
    r0 = rise_cnt;
    next_res = 10'h155;
    start_wr();
    start_wr();
    wait (cv_st == 3);
    // R8: start during conversion (busy high, line low)
    start_wr();
    repeat (3) @(negedge clk); #1;
    chk("R8 ignored during conversion", bc, 0);
    wait (cv_st == 0);
    repeat (SYNC + 4) @(negedge clk); #1;
    chk("R8 no deferred start", bc, 0);
    chk("R8 single pulse", rise_cnt - r0, 1);
    wait_done();
    rd_word(2'd0, a, b);
    chk("R4 word0 after R8", a, 8'h55);

    // R9: write strobe held low across completion
    r0 = rise_cnt;
    next_res = 10'h1C3;
    start_wr(1);
    @(negedge clk); cs_ni = 0; sel = 2'd3;
    wait (cv_st == 3);
    wait (cv_st == 0);
    repeat (SYNC + 4) @(negedge clk); #1;
    chk("R9 held strobe no restart", rise_cnt - r0, 1);
    @(negedge clk); wr_ni = 1; cs_ni = 1; sel = 2'd0;

    // R9: writes to other selects
    r0 = rise_cnt;
    plain_wr(2'd0); plain_wr(2'd1); plain_wr(2'd2);
    repeat (4) @(negedge clk); #1;
    chk("R9 non-start write", rise_cnt - r0, 0);
    chk("R9 line low", bc, 0);

    // R5: read strobe without chip select
    @(negedge clk); cs_ni = 1; sel = 2'd0; rd_ni = 0;
    #1;
    chk("R5 no cs no enable", en0, 0);
    chk("R5 no cs data zero", d0, 0);
    @(negedge clk); cs_ni = 0; sel = 2'd3;
    #1;
    chk("R5 start select no enable", en0, 0);
    @(negedge clk); rd_ni = 1; cs_ni = 1;
    repeat (2) @(negedge clk);

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule